// File: doc/BRIEF.md
# Interprocessor Interrupt Command Sender

This block holds the two command words that software uses to interrupt other cores. A write to the low word starts a command. The block sends one interrupt message per target core on an outbound valid/ready port. It can also raise a one-cycle pulse into the local core's own request logic. Every message sent on the outbound port is later acknowledged through a single-bit return strobe.

A status bit in the low word stays at 1 while messages are still waiting to go out or still waiting for their acknowledgement. While that bit is 1, new commands are refused. A two-bit target selector picks one of four targets: a single named core, the local core alone, every core, or every core except the local one. `NUM_CORES` sets how many cores a broadcast walks through, and `LOCAL_ID` gives the local core's position in that numbering.

Top module: `ipi_cmd_sender`

## Requirements
- R1: After reset, both command words read 0, `msg_valid` is 0 and `self_valid` is 0.
- R2: The low word keeps these fields and reads every other bit as 0: vector [7:0], delivery mode [10:8], logical-destination flag [11], status [12], level [14], trigger [15] and target selector [19:18]. The high word keeps only the destination in [31:24]. A high-word write takes effect on the next clock edge, at any time.
- R3: An accepted low-word write with selector 0 sets status to 1 from the next cycle. One message then goes out to the destination held in the high word before the write. It carries the vector, mode, logical flag, level and trigger that were written.
- R4: Selector 1 pulses `self_valid` for one cycle, starting the cycle after the write, with the written vector, mode and trigger. It sends nothing outbound, and status reads 0 afterwards.
- R5: Selector 2 pulses `self_valid` as in R4. It also sends one message to every core except `LOCAL_ID`, in ascending core-number order.
- R6: Selector 3 sends one message to every core except `LOCAL_ID`, in ascending order, and does not pulse `self_valid`.
- R7: At most one message is transferred per cycle, on a cycle where `msg_valid` and `msg_ready` are both 1. While `msg_ready` is 0, `msg_valid` stays at 1 and the destination and payload do not change.
- R8: A low-word write while status is 1 is ignored: the readback does not change, and no message or self pulse results.
- R9: Status stays at 1 until every message has been transferred and an acknowledgement has come back for each one. It reads 0 on the cycle after the last acknowledgement.
- R10: An acknowledgement that arrives in the same cycle as a message transfer is counted correctly. After as many valid acknowledgements as messages, status is 0.
- R11: An acknowledgement that arrives while no acknowledgement is owed is ignored, so a later command still needs its full count of acknowledgements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_wr | input | 1 | Write strobe for the low command word |
| hi_wr | input | 1 | Write strobe for the high command word |
| wr_data | input | 32 | Write data for either word |
| lo_rdata | output | 32 | Low word readback, including status in bit 12 |
| hi_rdata | output | 32 | High word readback |
| msg_valid | output | 1 | Outbound message is present |
| msg_ready | input | 1 | Interconnect accepts the outbound message |
| msg_dest | output | DEST_W | Target core of the outbound message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_dest_logical | output | 1 | Message logical-destination flag |
| msg_level | output | 1 | Message level bit |
| msg_trigger | output | 1 | Message trigger bit |
| ack_valid | input | 1 | One acknowledgement returned |
| self_valid | output | 1 | One-cycle pulse into local request logic |
| self_vector | output | 8 | Vector of the local delivery |
| self_mode | output | 3 | Delivery mode of the local delivery |
| self_trigger | output | 1 | Trigger bit of the local delivery |

## Verification
The bench builds the block with `NUM_CORES = 5` and `LOCAL_ID = 2`. With the local core in the middle of the numbering, the skip falls in the middle of a broadcast walk rather than at either end. A broadcast then leaves up to four acknowledgements owed, so the counter uses more than one bit and can hold a value above 1. Backpressure alternating every cycle and acknowledgements held high across the transfer cycles test the hold rule and the same-cycle counting together.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;

   // Low command word field positions (software-visible layout)
   localparam int VEC_LSB     = 0;
   localparam int VEC_W       = 8;
   localparam int MODE_LSB    = 8;
   localparam int MODE_W      = 3;
   localparam int DLOG_BIT    = 11;
   localparam int STAT_BIT    = 12;
   localparam int LVL_BIT     = 14;
   localparam int TRG_BIT     = 15;
   localparam int SH_LSB      = 18;
   // High command word destination field
   localparam int HI_DEST_LSB = 24;
   localparam int HI_DEST_W   = 8;

   // Bits of the low word that software can store
   localparam logic [31:0] LO_RW_MASK = 32'h000C_CFFF;

   typedef enum logic [1:0] {
      SH_TARGET = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } shorthand_e;

   typedef struct packed {
      logic [VEC_W-1:0]  vector;
      logic [MODE_W-1:0] mode;
      logic              dest_logical;
      logic              level;
      logic              trigger;
   } ipi_payload_t;

   function automatic ipi_payload_t lo_fields(input logic [31:0] w);
      ipi_payload_t p;
      p.vector       = w[VEC_LSB +: VEC_W];
      p.mode         = w[MODE_LSB +: MODE_W];
      p.dest_logical = w[DLOG_BIT];
      p.level        = w[LVL_BIT];
      p.trigger      = w[TRG_BIT];
      return p;
   endfunction

endpackage

// File: rtl/ipi_ack_counter.sv
module ipi_ack_counter #(
   parameter int MAX_OUT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   input  logic ack,
   output logic pending
);
   localparam int CNT_W = $clog2(MAX_OUT + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             ack_take;

   // stray acknowledgements (nothing owed) are dropped
   assign ack_take = ack && (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case ({issue, ack_take})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign pending = (cnt_q != '0);

   assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MAX_OUT))
      else $error("owed acknowledgement count above limit");

   assert_stray_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !issue && cnt_q == '0) |=> (cnt_q == '0))
      else $error("stray acknowledgement changed the count");

   assert_ack_with_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && issue && cnt_q != '0) |=> $stable(cnt_q))
      else $error("simultaneous issue and acknowledgement miscounted");

endmodule

// File: rtl/ipi_launch_seq.sv
module ipi_launch_seq
   import ipi_cmd_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int LOCAL_ID  = 0,
   parameter int DEST_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_uni,
   input  logic              start_bc,
   input  logic [DEST_W-1:0] uni_dest,
   input  ipi_payload_t      pay_in,
   input  logic              msg_ready,
   output logic              msg_valid,
   output logic [DEST_W-1:0] msg_dest,
   output ipi_payload_t      pay_out,
   output logic              issue
);
   localparam logic [DEST_W-1:0] SELF_ID    = DEST_W'(LOCAL_ID);
   localparam int                FIRST_PEER = (LOCAL_ID == 0) ? 1 : 0;
   localparam int                LAST_PEER  = (LOCAL_ID == NUM_CORES - 1) ?
                                              NUM_CORES - 2 : NUM_CORES - 1;

   logic              active_q;
   logic              bcast_q;
   logic [DEST_W-1:0] cursor_q;
   ipi_payload_t      pay_q;
   logic              bc_go;
   logic [DEST_W-1:0] next_peer;
   logic              at_last;

   generate
      if (NUM_CORES > 1) begin : g_peers
         logic [DEST_W-1:0] step1;
         assign bc_go     = start_bc;
         assign step1     = cursor_q + 1'b1;
         assign next_peer = (step1 == SELF_ID) ? step1 + 1'b1 : step1;
         assign at_last   = (cursor_q == DEST_W'(LAST_PEER));
      end else begin : g_lone
         // a lone core has nobody to broadcast to
         assign bc_go     = 1'b0;
         assign next_peer = '0;
         assign at_last   = 1'b1;
      end
   endgenerate

   assign issue = active_q && msg_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         bcast_q  <= 1'b0;
         cursor_q <= '0;
         pay_q    <= '0;
      end else if (start_uni) begin
         active_q <= 1'b1;
         bcast_q  <= 1'b0;
         cursor_q <= uni_dest;
         pay_q    <= pay_in;
      end else if (bc_go) begin
         active_q <= 1'b1;
         bcast_q  <= 1'b1;
         cursor_q <= DEST_W'(FIRST_PEER);
         pay_q    <= pay_in;
      end else if (issue) begin
         if (!bcast_q || at_last) active_q <= 1'b0;
         else                     cursor_q <= next_peer;
      end
   end

   assign msg_valid = active_q;
   assign msg_dest  = cursor_q;
   assign pay_out   = pay_q;

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dest) && $stable(pay_out)))
      else $error("outbound message changed under backpressure");

   assert_skip_self_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && bcast_q) |-> (msg_dest != SELF_ID))
      else $error("broadcast addressed the local core");

   assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> !(start_uni || start_bc))
      else $error("command started while messages in flight");

endmodule

// File: rtl/ipi_cmd_sender.sv
module ipi_cmd_sender
   import ipi_cmd_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int LOCAL_ID  = 0,
   parameter int DEST_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_wr,
   input  logic              hi_wr,
   input  logic [31:0]       wr_data,
   output logic [31:0]       lo_rdata,
   output logic [31:0]       hi_rdata,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [DEST_W-1:0] msg_dest,
   output logic [7:0]        msg_vector,
   output logic [2:0]        msg_mode,
   output logic              msg_dest_logical,
   output logic              msg_level,
   output logic              msg_trigger,
   input  logic              ack_valid,
   output logic              self_valid,
   output logic [7:0]        self_vector,
   output logic [2:0]        self_mode,
   output logic              self_trigger
);
   localparam int MAX_OUT = (NUM_CORES > 1) ? NUM_CORES - 1 : 1;

   generate
      if (NUM_CORES < 1 || NUM_CORES > (1 << DEST_W)) begin : g_bad_cores
         $error("NUM_CORES must lie in 1 .. 2**DEST_W");
      end
      if (LOCAL_ID < 0 || LOCAL_ID >= NUM_CORES) begin : g_bad_local
         $error("LOCAL_ID must name one of the cores");
      end
      if (DEST_W < 1 || DEST_W > HI_DEST_W) begin : g_bad_width
         $error("DEST_W must fit the high-word destination field");
      end
   endgenerate

   logic [31:0]          lo_q;
   logic [HI_DEST_W-1:0] hi_dest_q;
   logic                 self_q;
   logic [7:0]           self_vec_q;
   logic [2:0]           self_mode_q;
   logic                 self_trg_q;

   shorthand_e   sh;
   ipi_payload_t cmd_pay;
   ipi_payload_t msg_pay;
   logic         busy;
   logic         seq_active;
   logic         cnt_pending;
   logic         accept;
   logic         start_uni;
   logic         start_bc;
   logic         issue;

   assign sh        = shorthand_e'(wr_data[SH_LSB +: 2]);
   assign cmd_pay   = lo_fields(wr_data);
   assign busy      = seq_active | cnt_pending;
   assign accept    = lo_wr & ~busy;
   assign start_uni = accept & (sh == SH_TARGET);
   assign start_bc  = accept & ((sh == SH_ALL) | (sh == SH_OTHERS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q        <= '0;
         hi_dest_q   <= '0;
         self_q      <= 1'b0;
         self_vec_q  <= '0;
         self_mode_q <= '0;
         self_trg_q  <= 1'b0;
      end else begin
         self_q <= accept & ((sh == SH_SELF) | (sh == SH_ALL));
         if (accept) begin
            lo_q        <= wr_data & LO_RW_MASK;
            self_vec_q  <= cmd_pay.vector;
            self_mode_q <= cmd_pay.mode;
            self_trg_q  <= cmd_pay.trigger;
         end
         if (hi_wr) hi_dest_q <= wr_data[HI_DEST_LSB +: HI_DEST_W];
      end
   end

   ipi_launch_seq #(
      .NUM_CORES (NUM_CORES),
      .LOCAL_ID  (LOCAL_ID),
      .DEST_W    (DEST_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_uni (start_uni),
      .start_bc  (start_bc),
      .uni_dest  (hi_dest_q[DEST_W-1:0]),
      .pay_in    (cmd_pay),
      .msg_ready (msg_ready),
      .msg_valid (seq_active),
      .msg_dest  (msg_dest),
      .pay_out   (msg_pay),
      .issue     (issue)
   );

   ipi_ack_counter #(
      .MAX_OUT (MAX_OUT)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .issue   (issue),
      .ack     (ack_valid),
      .pending (cnt_pending)
   );

   assign lo_rdata         = lo_q | (32'(busy) << STAT_BIT);
   assign hi_rdata         = {hi_dest_q, {HI_DEST_LSB{1'b0}}};
   assign msg_valid        = seq_active;
   assign msg_vector       = msg_pay.vector;
   assign msg_mode         = msg_pay.mode;
   assign msg_dest_logical = msg_pay.dest_logical;
   assign msg_level        = msg_pay.level;
   assign msg_trigger      = msg_pay.trigger;
   assign self_valid       = self_q;
   assign self_vector      = self_vec_q;
   assign self_mode        = self_mode_q;
   assign self_trigger     = self_trg_q;

   assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && lo_wr) |=> $stable(lo_q))
      else $error("low word changed while status was set");

   assert_self_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && sh == SH_SELF) |=> (!msg_valid && !busy && self_valid))
      else $error("self-only command left work behind");

   assert_uni_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && sh == SH_TARGET) |=>
         (msg_valid && msg_dest == $past(hi_dest_q[DEST_W-1:0])))
      else $error("unicast command did not target the high-word destination");

   assert_no_self_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && sh == SH_OTHERS) |=> !self_valid)
      else $error("exclude-self broadcast pulsed local delivery");

endmodule

// File: tb/ipi_cmd_sender_test.sv
`timescale 1ns/1ps
module ipi_cmd_sender_test;
   localparam int NC  = 5;
   localparam int LID = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lo_wr = 1'b0;
   logic        hi_wr = 1'b0;
   logic [31:0] wr_data = '0;
   logic        msg_ready = 1'b0;
   logic        ack_valid = 1'b0;
   logic [31:0] lo_rdata, hi_rdata;
   logic        msg_valid, msg_dest_logical, msg_level, msg_trigger;
   logic [7:0]  msg_dest, msg_vector, self_vector;
   logic [2:0]  msg_mode, self_mode;
   logic        self_valid, self_trigger;

   always #5 clk = ~clk;

   ipi_cmd_sender #(.NUM_CORES(NC), .LOCAL_ID(LID), .DEST_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .hi_wr(hi_wr), .wr_data(wr_data),
      .lo_rdata(lo_rdata), .hi_rdata(hi_rdata), .msg_valid(msg_valid),
      .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_vector(msg_vector),
      .msg_mode(msg_mode), .msg_dest_logical(msg_dest_logical),
      .msg_level(msg_level), .msg_trigger(msg_trigger), .ack_valid(ack_valid),
      .self_valid(self_valid), .self_vector(self_vector), .self_mode(self_mode),
      .self_trigger(self_trigger));

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string tag = "R1";

   // behavioural reference state
   int         ref_q[$];
   int         ref_out;
   logic [31:0] ref_lo;
   logic [7:0]  ref_hi;
   bit          ref_self;
   logic [7:0]  ref_vec;
   logic [2:0]  ref_mode;
   logic        ref_dl, ref_lvl, ref_trg;
   int          seen[$];

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic bit ref_busy();
      return (ref_q.size() > 0) || (ref_out > 0);
   endfunction

   task automatic compare_all();
      chk(tag, "lo_rdata", lo_rdata, ref_lo | (32'(ref_busy()) << 12));
      chk(tag, "hi_rdata", hi_rdata, {ref_hi, 24'h0});
      chk(tag, "msg_valid", 32'(msg_valid), 32'(ref_q.size() > 0));
      if (ref_q.size() > 0) begin
         chk(tag, "msg_dest", 32'(msg_dest), 32'(ref_q[0]));
         chk(tag, "msg_payload",
             32'({msg_vector, msg_mode, msg_dest_logical, msg_level, msg_trigger}),
             32'({ref_vec, ref_mode, ref_dl, ref_lvl, ref_trg}));
      end
      chk(tag, "self_valid", 32'(self_valid), 32'(ref_self));
      if (ref_self)
         chk(tag, "self_payload", 32'({self_vector, self_mode, self_trigger}),
             32'({ref_vec, ref_mode, ref_trg}));
   endtask

   task automatic tick();
      bit busy_pre, hs, ackd;
      logic [1:0] sh;
      if (rst_n && msg_valid && msg_ready) seen.push_back(int'(msg_dest));
      @(posedge clk);
      if (!rst_n) begin
         ref_q.delete();
         ref_out = 0; ref_lo = '0; ref_hi = '0; ref_self = 1'b0;
         ref_vec = '0; ref_mode = '0; ref_dl = 1'b0; ref_lvl = 1'b0; ref_trg = 1'b0;
      end else begin
         busy_pre = ref_busy();
         hs       = (ref_q.size() > 0) && msg_ready;
         ackd     = ack_valid && (ref_out > 0);
         ref_out  = ref_out + (hs ? 1 : 0) - (ackd ? 1 : 0);
         if (hs) void'(ref_q.pop_front());
         ref_self = 1'b0;
         if (lo_wr && !busy_pre) begin
            sh       = wr_data[19:18];
            ref_lo   = wr_data & 32'h000C_CFFF;
            ref_vec  = wr_data[7:0];
            ref_mode = wr_data[10:8];
            ref_dl   = wr_data[11];
            ref_lvl  = wr_data[14];
            ref_trg  = wr_data[15];
            if (sh == 2'd0) ref_q.push_back(int'(ref_hi));
            if (sh == 2'd2 || sh == 2'd3)
               for (int c = 0; c < NC; c++) if (c != LID) ref_q.push_back(c);
            if (sh == 2'd1 || sh == 2'd2) ref_self = 1'b1;
         end
         if (hi_wr) ref_hi = wr_data[31:24];
      end
      @(negedge clk);
      if (rst_n) compare_all();
   endtask

   task automatic write_lo(input logic [31:0] d);
      lo_wr = 1'b1; wr_data = d;
      tick();
      lo_wr = 1'b0; wr_data = '0;
   endtask

   task automatic write_hi(input logic [31:0] d);
      hi_wr = 1'b1; wr_data = d;
      tick();
      hi_wr = 1'b0; wr_data = '0;
   endtask

   task automatic check_peers(input string req);
      chk(req, "broadcast message count", 32'(seen.size()), 32'(NC - 1));
      for (int i = 0; i < seen.size(); i++)
         chk(req, "broadcast order", 32'(seen[i]), 32'(i < LID ? i : i + 1));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R9 watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      repeat (3) tick();
      rst_n = 1'b1;
      // R1 reset state
      tag = "R1";
      chk("R1", "lo after reset", lo_rdata, 32'h0);
      chk("R1", "hi after reset", hi_rdata, 32'h0);
      chk("R1", "msg_valid after reset", 32'(msg_valid), 32'h0);
      chk("R1", "self_valid after reset", 32'(self_valid), 32'h0);
      tick();

      // R2 field layout, R4 self-only
      tag = "R2";
      write_hi(32'hA5FF_FFFF);
      chk("R2", "hi keeps only destination", hi_rdata, 32'hA500_0000);
      tag = "R4";
      write_lo(32'hFFF7_FFFF);
      chk("R2", "lo reserved bits clear", lo_rdata, 32'h0004_CFFF);
      chk("R4", "self pulse", 32'(self_valid), 32'h1);
      chk("R4", "no outbound", 32'(msg_valid), 32'h0);
      tick();
      chk("R4", "self pulse ends", 32'(self_valid), 32'h0);

      // R3 unicast, R9 status lifetime
      tag = "R3";
      msg_ready = 1'b1;
      write_hi(32'h0300_0000);
      write_lo(32'h0000_C041);
      chk("R3", "status set", 32'(lo_rdata[12]), 32'h1);
      chk("R3", "unicast destination", 32'(msg_dest), 32'h3);
      tag = "R9";
      tick(); tick(); tick();
      chk("R9", "status held awaiting ack", 32'(lo_rdata[12]), 32'h1);
      ack_valid = 1'b1; tick(); ack_valid = 1'b0;
      chk("R9", "status cleared by ack", 32'(lo_rdata[12]), 32'h0);

      // R5 include-self broadcast, R7 backpressure, R8 busy write
      tag = "R5";
      seen.delete();
      msg_ready = 1'b0;
      write_lo(32'h0008_0F33);
      tag = "R7";
      tick(); tick();
      chk("R7", "held under backpressure", 32'(msg_valid), 32'h1);
      chk("R7", "destination stable", 32'(msg_dest), 32'h0);
      for (int k = 0; k < 12; k++) begin
         msg_ready = k[0];
         if (k == 3) begin
            tag = "R8";
            write_lo(32'h000C_0011);
            chk("R8", "busy write ignored", lo_rdata, 32'h0008_1F33);
            tag = "R7";
         end else tick();
      end
      msg_ready = 1'b0;
      check_peers("R5");
      tag = "R9";
      ack_valid = 1'b1;
      repeat (NC - 1) tick();
      ack_valid = 1'b0;
      chk("R9", "status clear after all acks", 32'(lo_rdata[12]), 32'h0);

      // R6 exclude-self broadcast with acks overlapping issue (R10)
      tag = "R6";
      seen.delete();
      msg_ready = 1'b1;
      ack_valid = 1'b1;
      write_lo(32'h000C_A205);
      tag = "R10";
      repeat (NC - 1) tick();
      chk("R10", "one ack still owed", 32'(lo_rdata[12]), 32'h1);
      tick();
      chk("R10", "status clear after overlapping acks", 32'(lo_rdata[12]), 32'h0);
      ack_valid = 1'b0;
      tick();
      check_peers("R6");

      // R11 stray acknowledgements
      tag = "R11";
      ack_valid = 1'b1;
      repeat (3) tick();
      ack_valid = 1'b0;
      chk("R11", "idle after stray acks", 32'(lo_rdata[12]), 32'h0);
      write_hi(32'h0200_0000);
      write_lo(32'h0000_0077);
      repeat (3) tick();
      chk("R11", "ack still owed after strays", 32'(lo_rdata[12]), 32'h1);
      ack_valid = 1'b1; tick(); ack_valid = 1'b0;
      chk("R11", "cleared by real ack", 32'(lo_rdata[12]), 32'h0);
      tick();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule